// File: doc/BRIEF.md
# Address Space Translator Selector

This block sits between a processor's memory bus and three address-translation units: one for instructions, one for data and one for stack. On every bus cycle it looks at the processor mode, the bus status, the 16-bit logical offset and the 7-bit segment number. From these it decides which unit handles the access. Instruction fetches always go to the code unit. Other accesses go to the data unit or to the stack unit, depending on how the offset compares with a break value. The break value comes from one of two break registers, picked by the processor mode.

The block also checks the segment number against the current configuration. User-mode accesses to reserved segments are flagged as violations. So are accesses to the upper segment bank while segmented user operation is disabled. A flagged access drives no unit select. The decision is registered once, so selects, the mode output and the violation flag appear one cycle after the access is presented. A small register port loads the two break registers and the configuration register.

Top module: `xlat_steer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all outputs are 0. Both break registers reset to 16'h8000 and the segmented-user enable resets to 0.
- R2: When `reg_we` is 1, `reg_addr` 0 loads the system break, 1 loads the normal break, and 2 loads the configuration register (bit 0 is the segmented-user enable). `reg_addr` 3 changes nothing. A write affects only accesses presented on later cycles; an access in the same cycle uses the old value.
- R3: `bus_stat` encoding: 2'b00 instruction fetch, 2'b01 data access, 2'b10 stack access, 2'b11 idle. An idle cycle gives `acc_valid`=0, `sel`=0, `viol`=0 and `sel_sys`=0 one cycle later.
- R4: An allowed fetch sets `sel`=3'b001 (code unit, bit 0), whatever the offset and break values.
- R5: An allowed data or stack access with offset ≥ the active break sets `sel`=3'b100 (stack unit, bit 2). Otherwise it sets `sel`=3'b010 (data unit, bit 1). Equality selects the stack unit.
- R6: The active break is the system break when `mode_sys`=1 and the normal break when `mode_sys`=0.
- R7: In system mode, every segment number 0 to 127 is allowed and `viol` stays 0.
- R8: In user mode, segments 2 to 63 are always allowed.
- R9: In user mode, segments 0, 1, 64 and 65 set `viol`=1 and `sel`=0, with `acc_valid`=1.
- R10: In user mode, segments 66 to 127 are allowed when the segmented-user enable is 1. When it is 0, they set `viol`=1 and `sel`=0.
- R11: For every non-idle access, `acc_valid`=1 and `sel_sys` equals the `mode_sys` of that access, one cycle after it is presented.
- R12: `sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sys | input | 1 | 1 = system mode, 0 = user (normal) mode |
| bus_stat | input | 2 | Bus status: 00 fetch, 01 data, 10 stack, 11 idle |
| offset | input | 16 | Logical offset of the access |
| seg | input | 7 | Segment number of the access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 system break, 1 normal break, 2 configuration |
| reg_wdata | input | 16 | Register write data |
| sel | output | 3 | One-hot unit select: bit 0 code, bit 1 data, bit 2 stack |
| sel_sys | output | 1 | Mode of the selected access for the chosen unit |
| viol | output | 1 | Segment violation for the access |
| acc_valid | output | 1 | A non-idle access was decided |

## Verification
A wrong break register or a stale enable bit shows up at the ports only when an access tests it. It then appears as a data/stack swap or a spurious violation one cycle after that access. The bench therefore places accesses exactly at and on both sides of each break value, in both modes. It places an access in the same cycle as a write, and one in the cycle after, to pin down when a write takes effect. It probes the segment boundaries 0, 1, 2, 63, 64, 65, 66 and 127 with the enable bit both clear and set. A corrupted output register would show as a wrong select or mode bit on the very next cycle, which every scoreboard comparison catches.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int UNITS  = 3;
  localparam int U_CODE = 0;
  localparam int U_DATA = 1;
  localparam int U_STK  = 2;

  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_DATA  = 2'b01,
    ST_STACK = 2'b10,
    ST_IDLE  = 2'b11
  } bus_stat_e;

  typedef enum logic [1:0] {
    RA_SYS_BRK = 2'd0,
    RA_NRM_BRK = 2'd1,
    RA_CFG     = 2'd2,
    RA_NONE    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/xs_regs.sv
module xs_regs #(
  parameter int OFS_W   = 16,
  parameter int DATA_W  = 16,
  parameter logic [OFS_W-1:0] BRK_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [OFS_W-1:0]  sys_brk,
  output logic [OFS_W-1:0]  nrm_brk,
  output logic              segusr_en
);
  import xs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_brk   <= BRK_RST;
      nrm_brk   <= BRK_RST;
      segusr_en <= 1'b0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        RA_SYS_BRK: sys_brk   <= wdata[OFS_W-1:0];
        RA_NRM_BRK: nrm_brk   <= wdata[OFS_W-1:0];
        RA_CFG:     segusr_en <= wdata[0];
        default: ;
      endcase
    end
  end

  p_sys_write_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2'd0) |=> (sys_brk == $past(wdata[OFS_W-1:0])));
  p_nrm_write_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2'd1) |=> (nrm_brk == $past(wdata[OFS_W-1:0])));
  p_none_write_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2'd3) |=> ($stable(sys_brk) && $stable(nrm_brk) && $stable(segusr_en)));
endmodule

// File: rtl/xs_seg_check.sv
module xs_seg_check #(
  parameter int SEG_W = 7
) (
  input  logic             mode_sys,
  input  logic [SEG_W-1:0] seg,
  input  logic             segusr_en,
  output logic             bad
);
  localparam int LOW_W = SEG_W - 1;

  logic [LOW_W-1:0] seg_low;
  logic             seg_upper;
  logic             reserved;

  always_comb begin
    seg_low   = seg[LOW_W-1:0];
    seg_upper = seg[SEG_W-1];
    reserved  = (seg_low < LOW_W'(2));
    if (mode_sys) bad = 1'b0;
    else          bad = reserved || (seg_upper && !segusr_en);
  end
endmodule

// File: rtl/xs_route.sv
module xs_route #(
  parameter int OFS_W = 16
) (
  input  logic [1:0]                 bus_stat,
  input  logic                       mode_sys,
  input  logic [OFS_W-1:0]           offset,
  input  logic [OFS_W-1:0]           sys_brk,
  input  logic [OFS_W-1:0]           nrm_brk,
  input  logic                       bad,
  output logic [xs_pkg::UNITS-1:0]   sel_nx,
  output logic                       act_nx,
  output logic                       viol_nx
);
  import xs_pkg::*;

  logic [OFS_W-1:0] brk;
  logic             at_or_above;

  always_comb begin
    brk         = mode_sys ? sys_brk : nrm_brk;
    at_or_above = (offset >= brk);
    sel_nx      = '0;
    act_nx      = 1'b0;
    viol_nx     = 1'b0;
    if (bus_stat_e'(bus_stat) != ST_IDLE) begin
      act_nx = 1'b1;
      if (bad) begin
        viol_nx = 1'b1;
      end else if (bus_stat_e'(bus_stat) == ST_FETCH) begin
        sel_nx[U_CODE] = 1'b1;
      end else if (at_or_above) begin
        sel_nx[U_STK] = 1'b1;
      end else begin
        sel_nx[U_DATA] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_steer.sv
module xlat_steer #(
  parameter int OFS_W  = 16,
  parameter int SEG_W  = 7,
  parameter int DATA_W = 16,
  parameter logic [OFS_W-1:0] BRK_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sys,
  input  logic [1:0]        bus_stat,
  input  logic [OFS_W-1:0]  offset,
  input  logic [SEG_W-1:0]  seg,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [2:0]        sel,
  output logic              sel_sys,
  output logic              viol,
  output logic              acc_valid
);
  import xs_pkg::*;

  localparam int HALF = 1 << (SEG_W - 1);

  logic [OFS_W-1:0] sys_brk, nrm_brk;
  logic             segusr_en;
  logic             bad;
  logic [UNITS-1:0] sel_nx;
  logic             act_nx, viol_nx;

  xs_regs #(.OFS_W(OFS_W), .DATA_W(DATA_W), .BRK_RST(BRK_RST)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sys_brk(sys_brk), .nrm_brk(nrm_brk), .segusr_en(segusr_en)
  );

  xs_seg_check #(.SEG_W(SEG_W)) u_seg (
    .mode_sys(mode_sys), .seg(seg), .segusr_en(segusr_en), .bad(bad)
  );

  xs_route #(.OFS_W(OFS_W)) u_route (
    .bus_stat(bus_stat), .mode_sys(mode_sys), .offset(offset),
    .sys_brk(sys_brk), .nrm_brk(nrm_brk), .bad(bad),
    .sel_nx(sel_nx), .act_nx(act_nx), .viol_nx(viol_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= '0;
      sel_sys   <= 1'b0;
      viol      <= 1'b0;
      acc_valid <= 1'b0;
    end else begin
      sel       <= sel_nx;
      sel_sys   <= act_nx & mode_sys;
      viol      <= viol_nx;
      acc_valid <= act_nx;
    end
  end

  p_sel_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  p_viol_nosel_r9: assert property (@(posedge clk) disable iff (rst)
    viol |-> (sel == 3'b000 && acc_valid));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_stat == 2'b11) |=> (!acc_valid && sel == 3'b000 && !viol));
  p_sys_fetch_code_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_sys && bus_stat == 2'b00) |=> (sel == 3'b001 && !viol));
  p_sys_noviol_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_sys && bus_stat != 2'b11) |=> (!viol && sel_sys && acc_valid));
  p_user_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (!mode_sys && bus_stat != 2'b11 &&
     (seg == 0 || seg == 1 || seg == HALF || seg == HALF + 1)) |=> (viol && !sel_sys));
endmodule

// File: tb/xlat_steer_test.sv
module xlat_steer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sys = 1'b0;
  logic [1:0]  bus_stat = 2'b11;
  logic [15:0] offset = '0;
  logic [6:0]  seg = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  sel;
  logic        sel_sys, viol, acc_valid;

  always #2.5 clk = ~clk;

  xlat_steer uut (
    .clk(clk), .rst(rst), .mode_sys(mode_sys), .bus_stat(bus_stat),
    .offset(offset), .seg(seg), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sel(sel), .sel_sys(sel_sys), .viol(viol),
    .acc_valid(acc_valid)
  );

  typedef struct {
    int         due;
    logic [2:0] sel;
    logic       sys;
    logic       viol;
    logic       act;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [15:0] m_sys_brk = 16'h8000;
  logic [15:0] m_nrm_brk = 16'h8000;
  logic        m_en      = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sel !== it.sel || sel_sys !== it.sys || viol !== it.viol || acc_valid !== it.act) begin
        fails++;
        $display("FAIL %s: sel=%b sys=%b viol=%b act=%b expected sel=%b sys=%b viol=%b act=%b",
                 it.tag, sel, sel_sys, viol, acc_valid, it.sel, it.sys, it.viol, it.act);
      end
    end
  end

  task automatic step(input logic we, input logic [1:0] ra, input logic [15:0] wd,
                      input logic md, input logic [1:0] st, input logic [15:0] ofs,
                      input logic [6:0] sg, input string tag);
    item_t it;
    logic [15:0] brk;
    reg_we = we; reg_addr = ra; reg_wdata = wd;
    mode_sys = md; bus_stat = st; offset = ofs; seg = sg;
    it.due = cyc + 1; it.tag = tag;
    it.sel = 3'b000; it.sys = 1'b0; it.viol = 1'b0; it.act = 1'b0;
    brk = md ? m_sys_brk : m_nrm_brk;
    if (st != 2'b11) begin
      it.act = 1'b1;
      it.sys = md;
      if (!md && (sg[5:0] < 6'd2 || (sg[6] && !m_en))) it.viol = 1'b1;
      else if (st == 2'b00) it.sel = 3'b001;
      else if (ofs >= brk) it.sel = 3'b100;
      else it.sel = 3'b010;
    end
    q.push_back(it);
    if (we) begin
      if (ra == 2'd0) m_sys_brk = wd;
      else if (ra == 2'd1) m_nrm_brk = wd;
      else if (ra == 2'd2) m_en = wd[0];
    end
    @(negedge clk);
  endtask

  task automatic acc(input logic md, input logic [1:0] st, input logic [15:0] ofs,
                     input logic [6:0] sg, input string tag);
    step(1'b0, 2'd0, 16'h0, md, st, ofs, sg, tag);
  endtask

  task automatic wr(input logic [1:0] ra, input logic [15:0] wd, input string tag);
    step(1'b1, ra, wd, 1'b0, 2'b11, 16'h0, 7'd0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (sel !== 3'b000 || sel_sys !== 1'b0 || viol !== 1'b0 || acc_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: sel=%b sys=%b viol=%b act=%b expected all 0",
               sel, sel_sys, viol, acc_valid);
    end
    rst = 1'b0;
    acc(1'b0, 2'b11, 16'h0, 7'd5, "R1 R3 idle after reset");
    acc(1'b1, 2'b01, 16'h7FFF, 7'd0, "R1 R5 below reset break");
    acc(1'b1, 2'b10, 16'h8000, 7'd0, "R1 R5 equal to reset break");
    acc(1'b0, 2'b01, 16'h8000, 7'd2, "R1 R6 user reset break");
    acc(1'b1, 2'b00, 16'hFFFF, 7'd0, "R4 sys fetch high offset");
    acc(1'b0, 2'b00, 16'h0000, 7'd10, "R4 R11 user fetch low offset");
    wr(2'd0, 16'h1000, "R2 write sys break");
    wr(2'd1, 16'hC000, "R2 write normal break");
    acc(1'b1, 2'b01, 16'h0FFF, 7'd0, "R6 sys below 1000");
    acc(1'b1, 2'b01, 16'h1000, 7'd0, "R5 R6 sys at 1000");
    acc(1'b0, 2'b10, 16'h1000, 7'd3, "R6 user uses normal break");
    acc(1'b0, 2'b10, 16'hC000, 7'd3, "R5 R6 user at C000");
    acc(1'b0, 2'b01, 16'hBFFF, 7'd63, "R8 user seg 63");
    step(1'b1, 2'd0, 16'h0000, 1'b1, 2'b01, 16'h0800, 7'd0, "R2 same cycle old break");
    acc(1'b1, 2'b01, 16'h0800, 7'd0, "R2 new break next cycle");
    wr(2'd3, 16'hFFFF, "R2 write addr 3");
    acc(1'b0, 2'b01, 16'hBFFF, 7'd2, "R2 addr3 no change nrm");
    acc(1'b0, 2'b01, 16'h0000, 7'd66, "R2 R10 addr3 no enable");
    acc(1'b0, 2'b01, 16'h0, 7'd0, "R9 user seg 0");
    acc(1'b0, 2'b10, 16'h0, 7'd1, "R9 user seg 1");
    acc(1'b0, 2'b00, 16'h0, 7'd64, "R9 user seg 64");
    acc(1'b0, 2'b01, 16'h0, 7'd65, "R9 user seg 65");
    acc(1'b0, 2'b01, 16'h0, 7'd127, "R10 seg 127 disabled");
    acc(1'b1, 2'b01, 16'h0, 7'd1, "R7 sys seg 1");
    acc(1'b1, 2'b00, 16'h0, 7'd64, "R7 sys seg 64");
    acc(1'b1, 2'b10, 16'h0, 7'd127, "R7 sys seg 127");
    step(1'b1, 2'd2, 16'h0001, 1'b0, 2'b01, 16'h0, 7'd66, "R10 same cycle enable old");
    acc(1'b0, 2'b01, 16'h0, 7'd66, "R10 seg 66 enabled");
    acc(1'b0, 2'b10, 16'hFFFF, 7'd127, "R10 seg 127 enabled");
    acc(1'b0, 2'b00, 16'h0, 7'd100, "R10 R4 fetch seg 100");
    acc(1'b0, 2'b01, 16'h0, 7'd65, "R9 seg 65 still reserved");
    acc(1'b0, 2'b01, 16'h0, 7'd2, "R8 user seg 2");
    wr(2'd2, 16'h0000, "R2 clear enable");
    acc(1'b0, 2'b01, 16'h0, 7'd66, "R10 seg 66 disabled again");
    acc(1'b1, 2'b11, 16'h0, 7'd0, "R3 sys idle");
    for (int i = 0; i < 8; i++)
      acc(i[0], 2'(i % 3), 16'(i * 16'h2345), 7'(2 + i * 7), "R11 R12 mixed");
    acc(1'b0, 2'b11, 16'h0, 7'd0, "R3 final idle");
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1;
  end

  initial begin
    int w;
    w = 0;
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run not finished, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule